// File: doc/BRIEF.md
# Boot Image Signature Scanner

This block is a bus-master search engine that looks for a bootable image in a byte-addressed space of `2^ADDR_W` bytes. After a start pulse it walks the space in 512-byte pages, beginning with the highest page and moving down. In each page it reads the header words at byte offsets 0, 4, 8, 12, 16 and 20, one read at a time. It checks each word as it arrives. The first page whose six header words all pass is taken as the image. The scanner then reports that page's base address, the image size in pages, and the address where execution starts. That start address is the page base plus the offset stored in the header. The image is run where it lies and is never copied. When no page passes, the scan ends after page 0 and reports failure.

Reads leave on a request stream (`req_valid`/`req_ready`/`req_addr`). Answers come back on a response stream (`rsp_valid`/`rsp_ready`/`rsp_data`/`rsp_err`). A request is transferred on a cycle where both `req_valid` and `req_ready` are high. While `req_valid` is high and `req_ready` is low, the scanner holds `req_valid` high and keeps `req_addr` unchanged. Only one read is in flight at a time. `rsp_ready` is raised only while that read is outstanding, and a response is consumed on the cycle where `rsp_valid` and `rsp_ready` are both high. The responder may hold off its answer for any number of cycles. It sets `rsp_err` to signal a timeout or a missing answer. `start`, `busy`, `done` and `fail` are plain level or pulse pins.

Top module: `bootsig_scan`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `fail`, `req_valid` and `rsp_ready` are 0.
- R2: A `start` seen while idle begins a scan. The first read is at the top page base, `2^ADDR_W - 512`, offset 0. Within a page, reads go to offsets 0, 4, 8, 12, 16 and 20 in ascending order.
- R3: Pages are searched from the highest index down to page 0. The first page that passes wins, so a passing page at a higher address hides any passing page below it.
- R4: A response with `rsp_err` = 1 ends the check of the current page. The next read is offset 0 of the next lower page.
- R5: Words are little-endian, with header byte k of a word at bits [8k+7:8k]. Word 0 passes only if byte 0 = 0x18, byte 1 = 0x00, and byte 3 equals the bitwise inverse of (byte 0 + byte 1 + byte 2) modulo 256. Byte 2 may take any value.
- R6: Word 1 passes only if its byte 0 = 0x00 and its byte 1 = 0x01. Its bytes 2 and 3 are ignored.
- R7: Word 3 must be 0. Word 5 must equal (word 2 + word 3 + word 4) modulo 2^32. A word that fails any check ends the page at once, with no further reads in that page.
- R8: When a page passes, the scan stops with `done` = 1 and `fail` = 0. `img_base` is set to the page base, `img_pages` to word 2, and `img_entry` to (page base + word 4) modulo 2^32.
- R9: If page 0 does not pass, the scan stops with `done` = 1 and `fail` = 1. The page index never wraps past 0.
- R10: `req_addr` and `req_valid` are held steady while a request is stalled. At most one read is outstanding at any time.
- R11: `start` has no effect while `busy` is high. `done`, `fail` and the result outputs hold their values until the next accepted `start`, which clears `done` and `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | ADDR_W | Byte address of the read |
| rsp_valid | input | 1 | Read response valid |
| rsp_ready | output | 1 | Scanner accepts a response |
| rsp_data | input | 32 | Read data, little-endian |
| rsp_err | input | 1 | Timeout or missing answer for this read |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished |
| fail | output | 1 | Scan finished with no image found |
| img_base | output | ADDR_W | Base address of the winning page |
| img_pages | output | 32 | Image size in pages |
| img_entry | output | 32 | Execution start address |

## Verification
The hardest case to reach from the ports is a page that fails partway through its header. Such a page may fail on a late word, such as a bad sum in word 5 or a timeout on word 4. The scanner must then drop that page cleanly and restart at offset 0 of the page below, and it must not carry the size or offset it captured along with it. The stimulus builds pages that are valid apart from one chosen fault: a wrong inverse byte, a wrong version byte, a non-zero reserved word, a bad sum, or a timeout placed on a random word. It stacks these above a good page. The bench works out the exact address of every read it expects and checks each request against it, together with the final result. A directed case also sends a second `start` in the middle of a scan, to show that the request sequence carries on without restarting.

// File: rtl/bootsig_pkg.sv
package bootsig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } scan_st_e;

  localparam int          HDR_WORDS  = 6;
  localparam logic [2:0]  LAST_WORD  = 3'(HDR_WORDS - 1);
  localparam logic [7:0]  HDR_MAGIC  = 8'h18;
  localparam logic [7:0]  HDR_VER    = 8'h01;
  localparam logic [2:0]  W_SIZE     = 3'd2;
  localparam logic [2:0]  W_RSVD     = 3'd3;
  localparam logic [2:0]  W_OFFS     = 3'd4;
endpackage

// File: rtl/bootsig_pager.sv
module bootsig_pager #(
  parameter int PAGE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [PAGE_W-1:0] page_o,
  output logic              last_o
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     page_q <= '0;
    else if (load)  page_q <= '1;
    else if (step)  page_q <= page_q - 1'b1;
  end

  assign page_o = page_q;
  assign last_o = (page_q == '0);

  // R9: the index never steps below page 0
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> page_q != '0);
endmodule

// File: rtl/bootsig_hdrchk.sv
module bootsig_hdrchk
  import bootsig_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  idx,
  input  logic [31:0] data,
  input  logic        capture,
  output logic        word_ok,
  output logic [31:0] size_o,
  output logic [31:0] off_o
);
  logic [31:0] size_q, off_q;
  logic [7:0]  sum8;

  assign sum8 = data[7:0] + data[15:8] + data[23:16];

  always_comb begin
    unique case (idx)
      3'd0:    word_ok = (data[7:0] == HDR_MAGIC) && (data[15:8] == 8'h00)
                         && (data[31:24] == ~sum8);
      3'd1:    word_ok = (data[7:0] == 8'h00) && (data[15:8] == HDR_VER);
      3'd3:    word_ok = (data == 32'h0);
      3'd5:    word_ok = (data == size_q + off_q);
      3'd2,
      3'd4:    word_ok = 1'b1;
      default: word_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      off_q  <= '0;
    end else if (capture) begin
      if (idx == W_SIZE) size_q <= data;
      if (idx == W_OFFS) off_q  <= data;
    end
  end

  assign size_o = size_q;
  assign off_o  = off_q;

  // R2: header index stays inside the six-word header
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> idx <= LAST_WORD);
endmodule

// File: rtl/bootsig_scan.sv
module bootsig_scan
  import bootsig_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int PAGE_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  input  logic              rsp_err,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] img_base,
  output logic [31:0]       img_pages,
  output logic [31:0]       img_entry
);
  localparam int PAGE_W = ADDR_W - PAGE_LOG2;

  scan_st_e          st_q;
  logic [2:0]        widx_q;
  logic              done_q, fail_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       pages_q, entry_q;

  logic [PAGE_W-1:0] page_w;
  logic              last_w, load_w, step_w;
  logic              accept_w, word_ok_w, pass_w, reject_w;
  logic [31:0]       size_w, off_w;
  logic [ADDR_W-1:0] page_base_w;

  assign load_w   = (st_q == ST_IDLE) && start;
  assign accept_w = (st_q == ST_RSP) && rsp_valid;
  assign pass_w   = accept_w && !rsp_err && word_ok_w;
  assign reject_w = accept_w && !(!rsp_err && word_ok_w);
  assign step_w   = reject_w && !last_w;

  assign page_base_w = {page_w, {PAGE_LOG2{1'b0}}};

  bootsig_pager #(.PAGE_W(PAGE_W)) u_pager (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_w),
    .step   (step_w),
    .page_o (page_w),
    .last_o (last_w)
  );

  bootsig_hdrchk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (widx_q),
    .data    (rsp_data),
    .capture (pass_w),
    .word_ok (word_ok_w),
    .size_o  (size_w),
    .off_o   (off_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      widx_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      base_q  <= '0;
      pages_q <= '0;
      entry_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_REQ;
          widx_q <= '0;
          done_q <= 1'b0;
          fail_q <= 1'b0;
        end
        ST_REQ: if (req_ready) st_q <= ST_RSP;
        ST_RSP: if (accept_w) begin
          if (reject_w) begin
            widx_q <= '0;
            if (last_w) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              fail_q <= 1'b1;
            end else begin
              st_q <= ST_REQ;
            end
          end else if (widx_q == LAST_WORD) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            fail_q  <= 1'b0;
            base_q  <= page_base_w;
            pages_q <= size_w;
            entry_q <= 32'(page_base_w) + off_w;
          end else begin
            widx_q <= widx_q + 1'b1;
            st_q   <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == ST_REQ);
  assign rsp_ready = (st_q == ST_RSP);
  assign req_addr  = {page_w, {(PAGE_LOG2-5){1'b0}}, widx_q, 2'b00};
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign img_base  = base_q;
  assign img_pages = pages_q;
  assign img_entry = entry_q;

  // R10: a stalled request keeps its address
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R10: never a new request while a response is awaited
  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));
  // R11: a finished scan is idle and keeps done until restarted
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r11_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(img_entry) && $stable(fail));
  // R9: failure is only reported together with done
  a_r9_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  // R8: a reported image base is page aligned
  a_r8_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> img_base[PAGE_LOG2-1:0] == '0);
endmodule

// File: tb/bootsig_scan_bench.sv
module bootsig_scan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 14;
  localparam int PL   = 9;
  localparam int NPG  = 1 << (AW - PL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          req_valid, req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic          rsp_valid = 1'b0, rsp_ready;
  logic [31:0]   rsp_data = '0;
  logic          rsp_err = 1'b0;
  logic          busy, done, fail;
  logic [AW-1:0] img_base;
  logic [31:0]   img_pages, img_entry;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootsig_scan #(.ADDR_W(AW), .PAGE_LOG2(PL)) u_bootsig_scan (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .busy(busy), .done(done), .fail(fail),
    .img_base(img_base), .img_pages(img_pages), .img_entry(img_entry)
  );

  logic [31:0] mem_w   [NPG][6];
  logic [5:0]  mem_err [NPG];

  int n_chk = 0, n_fail = 0;
  int exp_page, exp_word;
  logic [31:0] trk_sz, trk_of;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit hdr_ok(int k, logic [31:0] w, logic [31:0] sz, logic [31:0] of);
    int s;
    case (k)
      0: begin
        s = int'(w[7:0]) + int'(w[15:8]) + int'(w[23:16]);
        return w[7:0] == 8'h18 && w[15:8] == 8'h00 && int'(w[31:24]) == 255 - (s % 256);
      end
      1: return w[7:0] == 8'h00 && w[15:8] == 8'h01;
      3: return w == 32'h0;
      5: return w == sz + of;
      default: return 1'b1;
    endcase
  endfunction

  // kind: 0 garbage, 1 valid, 2 bad inverse, 3 bad version, 4 rsvd nonzero,
  //       5 bad sum, 6 valid but timeout on a word, 7 unreadable
  task automatic make_page(input int p, input int kind);
    logic [7:0] b2;
    b2 = 8'($urandom);
    mem_w[p][0] = {~(8'h18 + b2), b2, 8'h00, 8'h18};
    mem_w[p][1] = {16'($urandom), 8'h01, 8'h00};
    mem_w[p][2] = $urandom;
    mem_w[p][3] = 32'h0;
    mem_w[p][4] = $urandom;
    mem_w[p][5] = mem_w[p][2] + mem_w[p][4];
    mem_err[p]  = 6'b0;
    case (kind)
      0: for (int i = 0; i < 6; i++) mem_w[p][i] = $urandom;
      2: mem_w[p][0][31:24] = mem_w[p][0][31:24] ^ 8'h10;
      3: mem_w[p][1][15:8] = 8'h02;
      4: begin mem_w[p][3] = 32'h100; mem_w[p][5] = mem_w[p][2] + mem_w[p][4] + 32'h100; end
      5: mem_w[p][5] = mem_w[p][5] + 32'd1;
      6: mem_err[p][$urandom % 6] = 1'b1;
      7: mem_err[p] = 6'h3f;
      default: ;
    endcase
  endtask

  task automatic expect_scan(output bit ef, output int ep, output logic [31:0] esz, output logic [31:0] eof);
    ef = 1'b1; ep = 0; esz = 0; eof = 0;
    for (int p = NPG - 1; p >= 0; p--) begin
      bit good;
      good = 1'b1;
      for (int k = 0; k < 6 && good; k++)
        if (mem_err[p][k] || !hdr_ok(k, mem_w[p][k], mem_w[p][2], mem_w[p][4])) good = 1'b0;
      if (good) begin
        ef = 1'b0; ep = p; esz = mem_w[p][2]; eof = mem_w[p][4];
        return;
      end
    end
  endtask

  // Memory responder with random back-pressure and latency
  initial begin
    bit pend, taken;
    int dly;
    logic [AW-1:0] stall_addr;
    bit stalled;
    pend = 0; taken = 0; dly = 0; stalled = 0; stall_addr = '0;
    forever begin
      @(negedge clk);
      if (stalled) begin
        chk(req_valid && req_addr == stall_addr, "R10 stalled request held", req_addr, stall_addr);
        stalled = 0;
      end
      if (taken) begin
        rsp_valid = 1'b0; pend = 0; taken = 0;
      end
      if (pend && !rsp_valid) begin
        if (dly == 0) begin
          logic [31:0] d;
          bit e, ok;
          d = mem_w[exp_page][exp_word];
          e = mem_err[exp_page][exp_word];
          rsp_valid = 1'b1; rsp_data = e ? 32'($urandom) : d; rsp_err = e;
          if (exp_word == 2) trk_sz = d;
          if (exp_word == 4) trk_of = d;
          ok = !e && hdr_ok(exp_word, d, trk_sz, trk_of);
          if (!ok) begin exp_page--; exp_word = 0; end
          else exp_word++;
        end else dly--;
      end
      if (rsp_valid && rsp_ready) taken = 1;
      req_ready = 1'b0;
      if (req_valid) begin
        chk(!pend, "R10 one read outstanding", pend, 0);
        if (!pend) begin
          logic [AW-1:0] ea;
          ea = AW'(exp_page * 512 + exp_word * 4);
          if ($urandom % 4 != 0) begin
            req_ready = 1'b1;
            chk(req_addr == ea, "R2 R3 R4 R7 read address sequence", req_addr, ea);
            pend = 1; dly = $urandom % 3;
          end else begin
            stalled = 1; stall_addr = req_addr;
          end
        end
      end
    end
  end

  task automatic run_scan(input bit poke, input string tag);
    bit ef; int ep; logic [31:0] esz, eof;
    int guard;
    logic [AW-1:0] eb;
    expect_scan(ef, ep, esz, eof);
    @(negedge clk);
    start = 1'b1; exp_page = NPG - 1; exp_word = 0; trk_sz = 0; trk_of = 0;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R11 start clears done", {busy, done}, 2'b10);
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 7) begin
        chk(busy, "R11 poke while busy", busy, 1);
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
    end
    if (!done) begin
      chk(0, "R9 scan did not finish", 0, 1);
      return;
    end
    eb = AW'(ep * 512);
    chk(fail == ef, {tag, " R8 R9 fail flag"}, fail, ef);
    if (!ef) begin
      chk(img_base == eb, {tag, " R3 R8 image base"}, img_base, eb);
      chk(img_pages == esz, {tag, " R8 image size"}, img_pages, esz);
      chk(img_entry == 32'(eb) + eof, {tag, " R8 entry address"}, img_entry, 32'(eb) + eof);
    end
    repeat (4) @(negedge clk);
    chk(done && fail == ef && !busy, "R11 results held", {done, fail}, {1'b1, ef});
  endtask

  task automatic fill(input int kind);
    for (int p = 0; p < NPG; p++) make_page(p, kind);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill(7);
    exp_page = NPG - 1; exp_word = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !req_valid && !rsp_ready, "R1 in reset",
        {busy, done, fail, req_valid, rsp_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !fail && !req_valid, "R1 after reset", {busy, done, fail, req_valid}, 0);

    // R9: nothing readable
    run_scan(0, "all-unreadable");
    // R3: only page 0 valid under garbage
    fill(0); make_page(0, 1);
    run_scan(0, "bottom-only");
    // R3: top page valid hides lower valid pages
    fill(1);
    run_scan(0, "top-wins");
    // R5: byte sum wraps; R7: word sum wraps
    fill(7); make_page(5, 1);
    mem_w[5][0] = {8'hF7, 8'hF0, 8'h00, 8'h18};
    mem_w[5][2] = 32'hFFFF_FFF0; mem_w[5][4] = 32'h0000_0020; mem_w[5][5] = 32'h0000_0010;
    run_scan(0, "R5 R7 wrap");
    // R6: bytes 2,3 of word 1 ignored, faulty pages above good one
    fill(0);
    make_page(NPG-1, 2); make_page(NPG-2, 3); make_page(NPG-3, 4);
    make_page(NPG-4, 5); make_page(NPG-5, 6); make_page(NPG-6, 1);
    mem_w[NPG-6][1][31:16] = 16'hBEEF;
    run_scan(0, "R4 R5 R6 R7 faults");
    // R11: start during scan ignored
    fill(0); make_page(3, 1);
    run_scan(1, "R11 poke");

    for (int t = 0; t < 30; t++) begin
      for (int p = 0; p < NPG; p++) begin
        int r;
        r = $urandom % 20;
        make_page(p, r < 6 ? 0 : r < 12 ? 7 : r < 17 ? 2 + (r - 12) : 1);
      end
      run_scan(t % 7 == 3, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule